// File: doc/BRIEF.md
# Clocked Digital Port Capture Unit

This block records the state of a 32-line digital port into a 16-entry sample queue. It takes one record on each active edge of a sample clock. The block never makes that clock itself. A select code picks it from one external pin or from one of six internal timing strobes. A polarity bit then chooses whether rising or falling edges count. The selected signal passes through a two-flop synchronizer into the system clock domain. Edge detection then turns it into a single-cycle sample strobe.

Each line has its own two-bit mode:
- A driven line outputs a bit from the output data register, with its enable asserted.
- A static line is readable on a plain status bus.
- A capture line contributes its level to the recorded word.

Lines that are not in capture mode record as zero. Recorded words leave the block through a valid/ready stream meant for a memory-moving reader. While `m_valid` is high and `m_ready` is low, the head word is held unchanged. A word leaves the queue on the clock edge where both are high.

If a strobe arrives while the queue is full, the new word is discarded, the queue contents are kept, and a sticky error flag is raised. Back-pressure is never applied to the sample source: the source cannot be stalled, so a full queue loses data. The flag stays set until a one-cycle clear pulse, and a new overflow in the same cycle as the clear keeps the flag set.

Top module: `port_capture_unit`

## Requirements
- R1: After reset, `m_valid` is 0, `ovf_flag` is 0 and `port_oe` is all zeros.
- R2: With `edge_fall`=0, each rising edge of the selected source enqueues exactly one word. With `edge_fall`=1, only falling edges enqueue. The word is visible on the stream output no later than 4 clock cycles after the edge.
- R3: `src_sel` code 1 selects `ext_clk`, and codes 2..7 select `int_src[code-2]`. Code 0 selects nothing, and no samples are taken.
- R4: Bit i of a recorded word equals `port_in[i]` when line i has mode 2'b10 (capture), and 0 otherwise. Line i's mode is `line_mode[2i+1:2i]`.
- R5: A line in mode 2'b01 has `port_oe[i]`=1 and `port_out[i]`=`out_data[i]`. Lines in any other mode have `port_oe[i]`=0 and `port_out[i]`=0.
- R6: `static_in[i]` equals `port_in[i]` for a line in mode 2'b00 or 2'b11, and is 0 otherwise.
- R7: While `cap_en` is 0, no strobe enqueues a word.
- R8: The queue holds 16 words and returns them in arrival order. A strobe that arrives while 16 words are held sets `ovf_flag`, drops the new word, and leaves the stored words unchanged.
- R9: `ovf_flag` stays 1 until a cycle with `ovf_clr`=1 and no new overflow, after which it reads 0.
- R10: While `m_valid`=1 and `m_ready`=0, `m_valid` stays 1 and `m_data` stays unchanged. A word is removed only on a cycle with both signals high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cap_en | input | 1 | Enables sampling |
| src_sel | input | 3 | Sample clock source code |
| edge_fall | input | 1 | 0 = rising edges sample, 1 = falling edges sample |
| ext_clk | input | 1 | External sample clock pin |
| int_src | input | 6 | Internal timing strobes |
| line_mode | input | 64 | Two mode bits per line |
| out_data | input | 32 | Values for driven lines |
| port_in | input | 32 | Port line levels |
| port_out | output | 32 | Driven line values |
| port_oe | output | 32 | Driven line enables |
| static_in | output | 32 | Levels of static-input lines |
| m_valid | output | 1 | Head word available |
| m_ready | input | 1 | Reader accepts head word |
| m_data | output | 32 | Head word |
| ovf_flag | output | 1 | Sticky overflow error |
| ovf_clr | input | 1 | Clears the overflow error |

## Verification
The bench walks through every source code. A mux that is wired wrong shows up as a missing or extra word, and the bench also checks that code 0 records nothing. Falling polarity is checked in the middle of a pulse, so a design that ignores the polarity bit produces a word one edge too early.

The bench fills the queue, then strobes once more. A design that overwrites a stored word, or that forgets to raise the flag, returns the wrong word order or a clear flag. The bench also stalls the reader to show that the head word holds steady under back-pressure. A mixed mode map shows whether a non-capture line leaks into the recorded word or onto the output enables.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    LM_STATIC     = 2'b00,
    LM_DRIVE      = 2'b01,
    LM_CAPTURE    = 2'b10,
    LM_STATIC_ALT = 2'b11
  } line_mode_e;
endpackage

// File: rtl/pcu_strobe_gen.sv
module pcu_strobe_gen #(
  parameter int N_INT = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             edge_fall,
  input  logic             ext_clk,
  input  logic [N_INT-1:0] int_src,
  output logic             strobe
);
  logic picked;
  logic s1, s2, s3;

  // code 0: nothing, 1: pin, 2..: internal strobes
  always_comb begin
    picked = 1'b0;
    if (src_sel == SEL_W'(1)) picked = ext_clk;
    for (int i = 0; i < N_INT; i++)
      if (src_sel == SEL_W'(i + 2)) picked = int_src[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
      s3 <= 1'b0;
    end else begin
      s1 <= picked;
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign strobe = edge_fall ? (~s2 & s3) : (s2 & ~s3);
endmodule

// File: rtl/pcu_line_ctrl.sv
module pcu_line_ctrl
  import pcu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [2*W-1:0] line_mode,
  input  logic [W-1:0]   out_data,
  input  logic [W-1:0]   port_in,
  output logic [W-1:0]   port_out,
  output logic [W-1:0]   port_oe,
  output logic [W-1:0]   static_in,
  output logic [W-1:0]   cap_word
);
  for (genvar i = 0; i < W; i++) begin : g_line
    line_mode_e m;
    assign m            = line_mode_e'(line_mode[2*i +: 2]);
    assign port_oe[i]   = (m == LM_DRIVE);
    assign port_out[i]  = (m == LM_DRIVE) & out_data[i];
    assign static_in[i] = ((m == LM_STATIC) | (m == LM_STATIC_ALT)) & port_in[i];
    assign cap_word[i]  = (m == LM_CAPTURE) & port_in[i];
  end
endmodule

// File: rtl/pcu_fifo.sv
module pcu_fifo #(
  parameter int DW    = 32,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  output logic          full,
  output logic          m_valid,
  input  logic          m_ready,
  output logic [DW-1:0] m_data
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_push, do_pop;

  assign full    = (count == (AW+1)'(DEPTH));
  assign m_valid = (count != '0);
  assign m_data  = mem[rd_ptr];
  assign do_push = push & ~full;
  assign do_pop  = m_valid & m_ready;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + AW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
      case ({do_push, do_pop})
        2'b10:   count <= count + (AW+1)'(1);
        2'b01:   count <= count - (AW+1)'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/port_capture_unit.sv
module port_capture_unit #(
  parameter int W     = 32,
  parameter int DEPTH = 16,
  parameter int N_INT = 6,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_en,
  input  logic [SEL_W-1:0] src_sel,
  input  logic             edge_fall,
  input  logic             ext_clk,
  input  logic [N_INT-1:0] int_src,
  input  logic [2*W-1:0]   line_mode,
  input  logic [W-1:0]     out_data,
  input  logic [W-1:0]     port_in,
  output logic [W-1:0]     port_out,
  output logic [W-1:0]     port_oe,
  output logic [W-1:0]     static_in,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [W-1:0]     m_data,
  output logic             ovf_flag,
  input  logic             ovf_clr
);
  logic         strobe, sample_evt, full;
  logic [W-1:0] cap_word;

  pcu_strobe_gen #(.N_INT(N_INT), .SEL_W(SEL_W)) u_strobe (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .edge_fall(edge_fall),
    .ext_clk(ext_clk), .int_src(int_src), .strobe(strobe)
  );

  pcu_line_ctrl #(.W(W)) u_lines (
    .line_mode(line_mode), .out_data(out_data), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe), .static_in(static_in),
    .cap_word(cap_word)
  );

  assign sample_evt = strobe & cap_en;

  pcu_fifo #(.DW(W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(sample_evt), .push_data(cap_word),
    .full(full), .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data)
  );

  // a new overflow wins over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ovf_flag <= 1'b0;
    else if (sample_evt & full) ovf_flag <= 1'b1;
    else if (ovf_clr)           ovf_flag <= 1'b0;
  end
endmodule

// File: rtl/pcu_checker.sv
module pcu_checker #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         cap_en,
  input logic         m_valid,
  input logic         m_ready,
  input logic [W-1:0] m_data,
  input logic         ovf_flag,
  input logic         ovf_clr,
  input logic [W-1:0] port_out,
  input logic [W-1:0] port_oe,
  input logic [W-1:0] static_in
);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R8
  ovf_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(m_valid));

  // R7
  no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cap_en && !m_valid) |=> !m_valid);

  // R5
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (port_out & ~port_oe) == '0);

  // R6
  static_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (static_in & port_oe) == '0);
endmodule

bind port_capture_unit pcu_checker #(.W(W)) u_pcu_checker (
  .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .m_valid(m_valid),
  .m_ready(m_ready), .m_data(m_data), .ovf_flag(ovf_flag),
  .ovf_clr(ovf_clr), .port_out(port_out), .port_oe(port_oe),
  .static_in(static_in)
);

// File: tb/port_capture_unit_bench.sv
module port_capture_unit_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        cap_en = 0;
  logic [2:0]  src_sel = 0;
  logic        edge_fall = 0;
  logic        ext_clk = 0;
  logic [5:0]  int_src = 0;
  logic [63:0] line_mode = 0;
  logic [31:0] out_data = 0;
  logic [31:0] port_in = 0;
  logic [31:0] port_out, port_oe, static_in, m_data;
  logic        m_valid, ovf_flag;
  logic        m_ready = 0;
  logic        ovf_clr = 0;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  localparam logic [63:0] ALL_CAP = {32{2'b10}};

  always #10 clk = ~clk;

  port_capture_unit u_port_capture_unit (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .src_sel(src_sel),
    .edge_fall(edge_fall), .ext_clk(ext_clk), .int_src(int_src),
    .line_mode(line_mode), .out_data(out_data), .port_in(port_in),
    .port_out(port_out), .port_oe(port_oe), .static_in(static_in),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_src(int sel, logic v);
    if (sel == 1) ext_clk = v;
    else if (sel >= 2) int_src[sel-2] = v;
  endtask

  task automatic pulse(int sel);
    set_src(sel, 1'b1);
    repeat (4) @(negedge clk);
    set_src(sel, 1'b0);
    repeat (4) @(negedge clk);
  endtask

  task automatic pop_expect(string tag, logic [31:0] exp);
    check({tag, " valid"}, {31'b0, m_valid}, 32'd1);
    check({tag, " data"}, m_data, exp);
    m_ready = 1;
    @(negedge clk);
    m_ready = 0;
  endtask

  task automatic t_reset;
    check("R1 m_valid", {31'b0, m_valid}, 32'd0);
    check("R1 ovf_flag", {31'b0, ovf_flag}, 32'd0);
    check("R1 port_oe", port_oe, 32'd0);
  endtask

  task automatic t_sources;
    line_mode = ALL_CAP;
    cap_en = 1;
    for (int s = 1; s < 8; s++) begin
      src_sel = 3'(s);
      port_in = 32'h1000_0000 + 32'(s);
      @(negedge clk);
      pulse(s);
    end
    for (int s = 1; s < 8; s++) pop_expect("R3 R2 source word", 32'h1000_0000 + 32'(s));
    check("R2 one word per edge", {31'b0, m_valid}, 32'd0);
    src_sel = 0;
    @(negedge clk);
    for (int s = 1; s < 8; s++) pulse(s);
    check("R3 code 0 no sample", {31'b0, m_valid}, 32'd0);
  endtask

  task automatic t_polarity;
    src_sel = 1;
    edge_fall = 1;
    port_in = 32'hCAFE_0001;
    @(negedge clk);
    ext_clk = 1;
    repeat (4) @(negedge clk);
    check("R2 falling mode ignores rise", {31'b0, m_valid}, 32'd0);
    ext_clk = 0;
    repeat (4) @(negedge clk);
    pop_expect("R2 falling edge word", 32'hCAFE_0001);
    edge_fall = 0;
    @(negedge clk);
  endtask

  task automatic t_modes;
    for (int i = 0; i < 32; i++)
      line_mode[2*i +: 2] = (i < 8) ? 2'b10 : (i < 16) ? 2'b01 : (i < 24) ? 2'b00 : 2'b11;
    port_in = 32'hA5C3_5AF0;
    out_data = 32'h1234_5678;
    @(negedge clk);
    check("R5 port_oe", port_oe, 32'h0000_FF00);
    check("R5 port_out", port_out, 32'h0000_5600);
    check("R6 static_in", static_in, 32'hA5C3_0000);
    pulse(1);
    pop_expect("R4 masked word", 32'h0000_00F0);
    line_mode = ALL_CAP;
  endtask

  task automatic t_cap_en;
    cap_en = 0;
    port_in = 32'h7777_7777;
    @(negedge clk);
    pulse(1);
    check("R7 disabled no sample", {31'b0, m_valid}, 32'd0);
    cap_en = 1;
  endtask

  task automatic t_overflow;
    for (int k = 0; k < 16; k++) begin
      port_in = 32'(k) + 32'h100;
      pulse(1);
    end
    check("R8 no overflow at 16", {31'b0, ovf_flag}, 32'd0);
    port_in = 32'hDEAD_BEEF;
    pulse(1);
    check("R8 overflow set", {31'b0, ovf_flag}, 32'd1);
    for (int k = 0; k < 16; k++) pop_expect("R8 order kept", 32'(k) + 32'h100);
    check("R8 dropped word absent", {31'b0, m_valid}, 32'd0);
    check("R9 flag sticky", {31'b0, ovf_flag}, 32'd1);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    check("R9 flag cleared", {31'b0, ovf_flag}, 32'd0);
  endtask

  task automatic t_backpressure;
    port_in = 32'h0000_AAAA;
    pulse(1);
    port_in = 32'h0000_BBBB;
    pulse(1);
    repeat (5) begin
      @(negedge clk);
      check("R10 head held", m_data, 32'h0000_AAAA);
    end
    pop_expect("R10 first", 32'h0000_AAAA);
    pop_expect("R10 second", 32'h0000_BBBB);
    check("R10 drained", {31'b0, m_valid}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_sources();
    t_polarity();
    t_modes();
    t_cap_en();
    t_overflow();
    t_backpressure();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule